// File: doc/BRIEF.md
# Twin-Clock Programmable-Flag FIFO

This block is a first-in first-out buffer for 9-bit words whose write side and read side run on clocks with no fixed relation. A producer writes on its own clock through a pair of qualifying enables. A consumer pulls words into a registered output on its clock through a second pair of enables. An output enable either drives that register onto the data pins or lets them float.

Four active-low status flags describe the fill level. Empty and almost-empty belong to the read clock. Full and almost-full belong to the write clock. The two almost thresholds come from offset values that a companion block supplies. Each side works out its flags from its own pointer and a Gray-coded copy of the other side's pointer, passed through a short synchroniser chain.

The storage depth is a parameter limited to 64, 256, 512 or 1024 words. One active-low asynchronous reset clears both sides.

Top module: `twin_clock_fifo9`

## Requirements
- R1: A word on `wr_data` is stored on a rising `wr_clk` edge exactly when `wr_en1_n`=0, `wr_en2`=1 and `full_n`=1 before that edge. If either enable is inactive, nothing is stored.
- R2: The FIFO never holds more than DEPTH words. While `full_n` is 0, no write is accepted and stored data is not overwritten.
- R3: On a rising `rd_clk` edge with `rd_en1_n`=0, `rd_en2_n`=0 and `empty_n`=1, the oldest word is loaded into the output register. If either read enable is 1, the output register keeps its value.
- R4: While `empty_n` is 0, the read enables are ignored: the output register and the read position do not change.
- R5: While `rst_n` is 0, the output register is 0, `full_n`=1, `afull_n`=1, `empty_n`=0, `aempty_n`=0, and both positions return to the first location.
- R6: `empty_n` is 0 whenever the read side sees no stored word. It goes to 1 within SYNC_STAGES+2 `rd_clk` edges of the first write. `full_n` goes to 0 on the `wr_clk` edge that stores the DEPTH-th word.
- R7: `aempty_n` is 0, updated on `rd_clk`, when the fill level seen by the read side is at most `ae_ofs` (for example, 7 words stored with `ae_ofs`=7 gives 0, and 8 words gives 1).
- R8: `afull_n` is 0, updated on `wr_clk`, when the fill level seen by the write side is at least DEPTH − `af_ofs`. It changes on the edge of the write that reaches that level.
- R9: With `out_en_n`=1, `rd_data` is high impedance. With `out_en_n`=0, `rd_data` carries the output register.
- R10: Words leave in the order they were accepted, for any mix of enables on the two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en1_n | input | 1 | Write enable, active low |
| wr_en2 | input | 1 | Write enable, active high |
| wr_data | input | DATA_W | Word to store |
| rd_en1_n | input | 1 | Read enable, active low |
| rd_en2_n | input | 1 | Read enable, active low |
| out_en_n | input | 1 | Drive `rd_data` when 0, float when 1 |
| ae_ofs | input | log2(DEPTH) | Almost-empty threshold |
| af_ofs | input | log2(DEPTH) | Almost-full threshold distance from full |
| rd_data | output | DATA_W | Output register, or high impedance |
| empty_n | output | 1 | 0 when empty (read clock) |
| aempty_n | output | 1 | 0 when almost empty (read clock) |
| full_n | output | 1 | 0 when full (write clock) |
| afull_n | output | 1 | 0 when almost full (write clock) |

## Verification
A corrupt pointer or a bad synchronised copy of one shows up at the ports in two ways. A word appears out of order or twice on `rd_data` at the first read after the fault. Or a flag sits on the wrong side of a threshold, at most a few read-clock edges after the synchroniser delivers the value. A full flag that rises too early lets a write overwrite unread data. That overwrite shows up only when the consumer reaches the overwritten slot, so the bench fills the buffer to its limit before it drains it. The threshold flags are checked one word either side of each offset, so a miscounted level shows up on the very write or read that crosses it.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;

   localparam int unsigned PTR_MAX_W = 11;

   typedef logic [PTR_MAX_W-1:0] ptr_t;

   function automatic ptr_t to_gray(ptr_t b);
      return b ^ (b >> 1);
   endfunction

   function automatic ptr_t from_gray(ptr_t g);
      ptr_t b;
      b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
      for (int i = PTR_MAX_W - 2; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/fifo9_sync.sv
module fifo9_sync #(
   parameter int W      = 7,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fifo9_sync needs at least two stages");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg[s] <= '0;
            end else begin
               stg[s] <= (s == 0) ? d : stg[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/fifo9_ram.sv
module fifo9_ram #(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 9,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              wr_clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) begin
         cells[waddr] <= wdata;
      end
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/fifo9_wside.sv
module fifo9_wside
   import fifo9_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = AW + 1
) (
   input  logic          wr_clk,
   input  logic          rst_n,
   input  logic          en1_n,
   input  logic          en2,
   input  logic [AW-1:0] af_ofs,
   input  logic [PW-1:0] rgray_s,
   output logic          wr_fire,
   output logic [AW-1:0] waddr,
   output logic [PW-1:0] wgray,
   output logic          full_n,
   output logic          afull_n
);

   localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

   logic [PW-1:0] wbin, wbin_nx, rbin_s, lvl_nx, lvl_now;

   assign rbin_s  = PW'(from_gray(ptr_t'(rgray_s)));
   assign wr_fire = !en1_n && en2 && full_n;
   assign wbin_nx = wbin + PW'(wr_fire);
   assign lvl_nx  = wbin_nx - rbin_s;
   assign lvl_now = wbin - rbin_s;
   assign waddr   = wbin[AW-1:0];

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin    <= '0;
         wgray   <= '0;
         full_n  <= 1'b1;
         afull_n <= 1'b1;
      end else begin
         wbin    <= wbin_nx;
         wgray   <= PW'(to_gray(ptr_t'(wbin_nx)));
         full_n  <= (lvl_nx != DEPTH_P);
         afull_n <= !(lvl_nx >= (DEPTH_P - PW'(af_ofs)));
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n) ($past(full_n) == 1'b0) |-> (wbin == $past(wbin))) else $error("write taken while full"); // R2
   AST_LEVEL_BOUND: assert property (@(posedge wr_clk) disable iff (!rst_n) lvl_now <= DEPTH_P) else $error("fill level above depth"); // R2
   AST_FULL_HONEST: assert property (@(posedge wr_clk) disable iff (!rst_n) full_n |-> (lvl_now != DEPTH_P)) else $error("full flag high with no room"); // R6

endmodule

// File: rtl/fifo9_rside.sv
module fifo9_rside
   import fifo9_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 9,
   localparam int AW    = $clog2(DEPTH),
   localparam int PW    = AW + 1
) (
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              en1_n,
   input  logic              en2_n,
   input  logic [AW-1:0]     ae_ofs,
   input  logic [PW-1:0]     wgray_s,
   input  logic [DATA_W-1:0] mem_q,
   output logic [AW-1:0]     raddr,
   output logic [PW-1:0]     rgray,
   output logic [DATA_W-1:0] q,
   output logic              empty_n,
   output logic              aempty_n
);

   logic          rd_fire;
   logic [PW-1:0] rbin, rbin_nx, wbin_s, lvl_nx;

   assign wbin_s  = PW'(from_gray(ptr_t'(wgray_s)));
   assign rd_fire = !en1_n && !en2_n && empty_n;
   assign rbin_nx = rbin + PW'(rd_fire);
   assign lvl_nx  = wbin_s - rbin_nx;
   assign raddr   = rbin[AW-1:0];

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin     <= '0;
         rgray    <= '0;
         q        <= '0;
         empty_n  <= 1'b0;
         aempty_n <= 1'b0;
      end else begin
         rbin     <= rbin_nx;
         rgray    <= PW'(to_gray(ptr_t'(rbin_nx)));
         if (rd_fire) begin
            q <= mem_q;
         end
         empty_n  <= (lvl_nx != '0);
         aempty_n <= !(lvl_nx <= PW'(ae_ofs));
      end
   end

   AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n) ($past(empty_n) == 1'b0) |-> ((rbin == $past(rbin)) && (q == $past(q)))) else $error("read taken while empty"); // R4
   AST_READ_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n) ($past(en1_n) || $past(en2_n)) |-> $stable(q)) else $error("output register moved without read"); // R3
   AST_EMPTY_HONEST: assert property (@(posedge rd_clk) disable iff (!rst_n) empty_n |-> (wbin_s != rbin)) else $error("empty flag high with nothing stored"); // R6

endmodule

// File: rtl/twin_clock_fifo9.sv
module twin_clock_fifo9
   import fifo9_pkg::*;
#(
   parameter int DEPTH       = 64,
   parameter int DATA_W      = 9,
   parameter int SYNC_STAGES = 2,
   localparam int AW         = $clog2(DEPTH),
   localparam int PW         = AW + 1
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              wr_en1_n,
   input  logic              wr_en2,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en1_n,
   input  logic              rd_en2_n,
   input  logic              out_en_n,
   input  logic [AW-1:0]     ae_ofs,
   input  logic [AW-1:0]     af_ofs,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty_n,
   output logic              aempty_n,
   output logic              full_n,
   output logic              afull_n
);

   generate
      if (!(DEPTH == 64 || DEPTH == 256 || DEPTH == 512 || DEPTH == 1024)) begin : g_bad_depth
         $error("twin_clock_fifo9: DEPTH must be 64, 256, 512 or 1024");
      end
      if (PW > PTR_MAX_W) begin : g_bad_ptr
         $error("twin_clock_fifo9: pointer wider than package limit");
      end
   endgenerate

   logic              wr_fire;
   logic [AW-1:0]     waddr, raddr;
   logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
   logic [DATA_W-1:0] mem_q, q_reg;

   fifo9_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
      .wr_clk (wr_clk),
      .we     (wr_fire),
      .waddr  (waddr),
      .wdata  (wr_data),
      .raddr  (raddr),
      .rdata  (mem_q)
   );

   fifo9_wside #(.DEPTH(DEPTH)) u_wside (
      .wr_clk  (wr_clk),
      .rst_n   (rst_n),
      .en1_n   (wr_en1_n),
      .en2     (wr_en2),
      .af_ofs  (af_ofs),
      .rgray_s (rgray_s),
      .wr_fire (wr_fire),
      .waddr   (waddr),
      .wgray   (wgray),
      .full_n  (full_n),
      .afull_n (afull_n)
   );

   fifo9_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk   (rd_clk),
      .rst_n (rst_n),
      .d     (wgray),
      .q     (wgray_s)
   );

   fifo9_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk   (wr_clk),
      .rst_n (rst_n),
      .d     (rgray),
      .q     (rgray_s)
   );

   fifo9_rside #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rside (
      .rd_clk   (rd_clk),
      .rst_n    (rst_n),
      .en1_n    (rd_en1_n),
      .en2_n    (rd_en2_n),
      .ae_ofs   (ae_ofs),
      .wgray_s  (wgray_s),
      .mem_q    (mem_q),
      .raddr    (raddr),
      .rgray    (rgray),
      .q        (q_reg),
      .empty_n  (empty_n),
      .aempty_n (aempty_n)
   );

   assign rd_data = out_en_n ? 'z : q_reg;

   AST_GRAY_STEP_W: assert property (@(posedge wr_clk) disable iff (!rst_n) $countones(wgray ^ $past(wgray)) <= 1) else $error("write pointer code moved more than one bit"); // R10
   AST_GRAY_STEP_R: assert property (@(posedge rd_clk) disable iff (!rst_n) $countones(rgray ^ $past(rgray)) <= 1) else $error("read pointer code moved more than one bit"); // R10

endmodule

// File: tb/twin_clock_fifo9_test.sv
module twin_clock_fifo9_test;

   localparam int DEPTH = 64;
   localparam int AW    = 6;

   logic       wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
   logic       wr_en1_n = 1'b1, wr_en2 = 1'b0, rd_en1_n = 1'b1, rd_en2_n = 1'b1;
   logic       out_en_n = 1'b0;
   logic [8:0] wr_data = '0;
   logic [AW-1:0] ae_ofs = 6'd7, af_ofs = 6'd7;
   wire  [8:0] rd_data;
   logic       empty_n, aempty_n, full_n, afull_n;

   int n_checks = 0, n_fail = 0;
   logic [8:0] model [$];
   logic [8:0] last_q = '0;

   always #10 wr_clk = ~wr_clk;
   always #17 rd_clk = ~rd_clk;

   twin_clock_fifo9 #(.DEPTH(DEPTH)) uut (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
      .wr_en1_n(wr_en1_n), .wr_en2(wr_en2), .wr_data(wr_data),
      .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .out_en_n(out_en_n),
      .ae_ofs(ae_ofs), .af_ofs(af_ofs), .rd_data(rd_data),
      .empty_n(empty_n), .aempty_n(aempty_n), .full_n(full_n), .afull_n(afull_n)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic do_write(input bit e1n, input bit e2, input logic [8:0] d);
      @(negedge wr_clk);
      wr_en1_n = e1n;
      wr_en2   = e2;
      wr_data  = d;
      if (!e1n && e2 && full_n) model.push_back(d);
      @(posedge wr_clk);
      #1;
      wr_en1_n = 1'b1;
      wr_en2   = 1'b0;
   endtask

   task automatic do_read(input bit e1n, input bit e2n, input string req);
      bit fire;
      logic [8:0] exp;
      @(negedge rd_clk);
      rd_en1_n = e1n;
      rd_en2_n = e2n;
      fire = !e1n && !e2n && empty_n;
      @(posedge rd_clk);
      #2;
      if (fire) begin
         if (model.size() == 0) begin
            check(1'b0, req, rd_data, 0);
         end else begin
            exp = model.pop_front();
            last_q = exp;
         end
      end
      check(rd_data == last_q, req, rd_data, last_q);
      rd_en1_n = 1'b1;
      rd_en2_n = 1'b1;
   endtask

   task automatic wait_rd(input int n);
      repeat (n) @(posedge rd_clk);
      #3;
   endtask

   task automatic wait_wr(input int n);
      repeat (n) @(posedge wr_clk);
      #3;
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      int filled;
      int guard;
      void'($urandom(32'd51966));
      #95;
      // R5: state while reset is held
      check(empty_n == 1'b0 && aempty_n == 1'b0, "R5 empty flags in reset", {empty_n, aempty_n}, 0);
      check(full_n == 1'b1 && afull_n == 1'b1, "R5 full flags in reset", {full_n, afull_n}, 3);
      check(rd_data == 9'h000, "R5 output register cleared", rd_data, 0);
      @(negedge wr_clk);
      #3;
      rst_n = 1'b1;

      // R1: inactive enables store nothing
      do_write(1'b0, 1'b0, 9'h111);
      do_write(1'b1, 1'b1, 9'h122);
      wait_rd(8);
      check(empty_n == 1'b0, "R1 rejected writes leave FIFO empty", empty_n, 0);

      // R6/R7: first word
      do_write(1'b0, 1'b1, 9'h1A5);
      filled = 1;
      wait_rd(4);
      check(empty_n == 1'b1, "R6 empty flag clears after first write", empty_n, 1);
      check(aempty_n == 1'b0, "R7 almost-empty with one word", aempty_n, 0);
      while (filled < 7) begin do_write(1'b0, 1'b1, 9'(filled)); filled++; end
      wait_rd(6);
      check(aempty_n == 1'b0, "R7 almost-empty at offset level", aempty_n, 0);
      do_write(1'b0, 1'b1, 9'h007); filled++;
      wait_rd(6);
      check(aempty_n == 1'b1, "R7 almost-empty clears above offset", aempty_n, 1);

      // R8: almost-full at DEPTH-7
      while (filled < DEPTH - 8) begin do_write(1'b0, 1'b1, 9'(filled * 5)); filled++; end
      check(afull_n == 1'b1, "R8 almost-full high below threshold", afull_n, 1);
      do_write(1'b0, 1'b1, 9'h0AA); filled++;
      check(afull_n == 1'b0, "R8 almost-full low at threshold", afull_n, 0);

      // R6/R2: full
      while (filled < DEPTH - 1) begin do_write(1'b0, 1'b1, 9'(filled * 3)); filled++; end
      check(full_n == 1'b1, "R6 full flag high one word short", full_n, 1);
      do_write(1'b0, 1'b1, 9'h155); filled++;
      check(full_n == 1'b0, "R6 full flag low at depth", full_n, 0);
      do_write(1'b0, 1'b1, 9'h0FF);
      check(full_n == 1'b0, "R2 full flag stays low after blocked write", full_n, 0);

      // R3/R9
      do_read(1'b0, 1'b0, "R3 first word out");
      check(rd_data == 9'h1A5, "R3 first word value", rd_data, 9'h1A5);
      out_en_n = 1'b1;
      #2;
      check(rd_data !== 9'h1A5, "R9 output floats when disabled", rd_data, 0);
      out_en_n = 1'b0;
      #2;
      check(rd_data == 9'h1A5, "R9 output driven when enabled", rd_data, 9'h1A5);
      do_read(1'b0, 1'b1, "R3 hold with one enable high");
      do_read(1'b1, 1'b0, "R3 hold with other enable high");

      // R10/R2: drain in order (blocked word must not appear)
      guard = 0;
      while (model.size() > 0 && guard < 200) begin do_read(1'b0, 1'b0, "R10 drain order"); guard++; end
      wait_rd(6);
      check(empty_n == 1'b0, "R6 empty after drain", empty_n, 0);
      do_read(1'b0, 1'b0, "R4 read ignored while empty");
      do_read(1'b0, 1'b0, "R4 second read ignored while empty");

      // R8: non-default offset
      af_ofs = 6'd3;
      ae_ofs = 6'd2;
      wait_wr(8);
      filled = 0;
      while (filled < DEPTH - 4) begin do_write(1'b0, 1'b1, 9'(filled + 100)); filled++; end
      check(afull_n == 1'b1, "R8 offset 3 below threshold", afull_n, 1);
      do_write(1'b0, 1'b1, 9'h033); filled++;
      check(afull_n == 1'b0, "R8 offset 3 at threshold", afull_n, 0);
      guard = 0;
      while (model.size() > 0 && guard < 200) begin do_read(1'b0, 1'b0, "R10 drain after offset test"); guard++; end
      af_ofs = 6'd7;
      ae_ofs = 6'd7;

      // R10: random traffic on both clocks
      fork
         for (int i = 0; i < 1500; i++) begin
            do_write(($urandom % 4) == 0, ($urandom % 5) != 0, 9'($urandom));
         end
         for (int k = 0; k < 1200; k++) begin
            do_read(($urandom % 3) == 0, ($urandom % 4) == 0, "R10 random order");
         end
      join
      guard = 0;
      while (model.size() > 0 && guard < 400) begin do_read(1'b0, 1'b0, "R10 random drain"); guard++; end
      wait_rd(6);
      check(empty_n == 1'b0 && model.size() == 0, "R10 all words delivered", empty_n, 0);

      // R5: reset during operation
      for (int i = 0; i < 5; i++) do_write(1'b0, 1'b1, 9'(i + 300));
      wait_rd(6);
      do_read(1'b0, 1'b0, "R3 read before mid reset");
      @(negedge wr_clk);
      rst_n = 1'b0;
      #4;
      check(empty_n == 1'b0 && aempty_n == 1'b0, "R5 mid-run reset empty flags", {empty_n, aempty_n}, 0);
      check(full_n == 1'b1 && afull_n == 1'b1, "R5 mid-run reset full flags", {full_n, afull_n}, 3);
      check(rd_data == 9'h000, "R5 mid-run reset output", rd_data, 0);
      model.delete();
      last_q = '0;
      @(negedge wr_clk);
      #3;
      rst_n = 1'b1;
      do_write(1'b0, 1'b1, 9'h0C3);
      wait_rd(6);
      do_read(1'b0, 1'b0, "R5 first word after reset");
      check(rd_data == 9'h0C3, "R5 pointers restart at first location", rd_data, 9'h0C3);

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule